// File: doc/BRIEF.md
# Static-Bank Cycle Termination Unit

This unit ends bus cycles for one static-memory chip-select bank. A small attribute register holds the bank's wait-state count and a two-bit termination code. The code either selects a port width, in which case the unit times the cycle internally, or hands termination to the responding device. When the cycle is timed internally, the unit counts the programmed wait states after the cycle starts. It then drives a two-line, active-low data-size acknowledge whose value encodes the port width. With the external-response code, the unit never drives the acknowledge lines. It ends the cycle when it samples an external acknowledge.

A mode input selects an alternate bus. In that mode a single active-low transfer acknowledge replaces the size pair, and the timing stays the same. External size acknowledges are sampled on the falling clock edge. The external transfer acknowledge is sampled on the rising edge. Even when the cycle is timed internally, an external acknowledge ends it early, and the unit then leaves its own lines undriven. A driven acknowledge stays on until chip-select negates. Each terminated cycle produces a one-clock done pulse.

Top module: `cs_cycle_term`

## Requirements
- R1: After reset all acknowledge outputs are high with their enables low and done is low. The attribute register holds a wait count of 14 and termination code 00.
- R2: For codes 00, 01 and 10, with a wait count N, done and the driven acknowledge appear N+1 clocks after the clock edge that samples cycle start with chip-select high.
- R3: Size acknowledge values on the active-low pair {line1,line0}: code 00 (32-bit) gives 00, code 01 (16-bit) gives 01 (only line 1 low), code 10 (8-bit) gives 10 (only line 0 low). The size enable is high only while one of these is driven.
- R4: With code 11 the unit drives no acknowledge line. It ignores the wait count and ends the cycle one clock edge after it samples either external size line low on a falling edge.
- R5: In alternate-bus mode with codes 00, 01 or 10, the transfer acknowledge goes low with its enable high, with the R2 timing. The size pair stays undriven.
- R6: In alternate-bus mode with code 11, an external transfer acknowledge that is low at a rising edge during the cycle ends it at that edge, and the unit drives nothing.
- R7: During an internally timed cycle, an external acknowledge ends the cycle before the count expires. It raises done and leaves all acknowledge enables low.
- R8: An external transfer acknowledge that is asserted and released before the cycle starts does not end the cycle.
- R9: A wait count of 0 terminates at the first clock edge after the cycle-start edge.
- R10: Done is a single-clock pulse. A driven acknowledge holds until chip-select is sampled low, and all outputs are idle after that edge.
- R11: If chip-select negates before termination, the cycle aborts with no done pulse and no acknowledge driven.
- R12: The wait counter reloads from the attribute register at every cycle start, so back-to-back cycles with different counts each get their own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Writes the attribute register |
| cfg_code | input | 2 | Termination code to store |
| cfg_wait | input | WAIT_W | Wait-state count to store |
| alt_bus | input | 1 | Alternate-bus mode, captured at cycle start |
| cyc_start | input | 1 | Cycle start strobe |
| cs_act | input | 1 | Chip-select of this bank, active high |
| ext_sz_ack_n | input | 2 | External size acknowledge, active low |
| ext_xfer_ack_n | input | 1 | External transfer acknowledge, active low |
| sz_ack_n | output | 2 | Driven size acknowledge, active low |
| sz_ack_oe | output | 1 | Drive enable of the size pair |
| xfer_ack_n | output | 1 | Driven transfer acknowledge, active low |
| xfer_ack_oe | output | 1 | Drive enable of the transfer acknowledge |
| done | output | 1 | One-clock cycle-terminated pulse |

## Verification
A wrong counter value shows up as done arriving early or late, so the latency that the bench measures from the start edge reveals it exactly. A wrong captured code or mode shows up on the first acknowledge clock as the wrong line pattern or the wrong enable. A stuck state shows up within one clock after chip-select negates, as an enable that stays high, or as a done pulse on an aborted cycle.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK} cst_state_t;

  localparam logic [1:0] CODE_W32 = 2'b00;
  localparam logic [1:0] CODE_W16 = 2'b01;
  localparam logic [1:0] CODE_W8  = 2'b10;
  localparam logic [1:0] CODE_EXT = 2'b11;

  // Active-low size acknowledge pattern for a port-width code.
  function automatic logic [1:0] size_ack_pattern(input logic [1:0] code);
    case (code)
      CODE_W32: size_ack_pattern = 2'b00;
      CODE_W16: size_ack_pattern = 2'b01;
      CODE_W8:  size_ack_pattern = 2'b10;
      default:  size_ack_pattern = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/cst_attr_reg.sv
module cst_attr_reg #(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned BOOT_WAIT = 14,
  parameter logic [1:0] BOOT_CODE = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        code_in,
  input  logic [WAIT_W-1:0] wait_in,
  output logic [1:0]        code_q,
  output logic [WAIT_W-1:0] wait_q
);
  localparam logic [WAIT_W-1:0] BOOT_WAIT_V = WAIT_W'(BOOT_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= BOOT_CODE;
      wait_q <= BOOT_WAIT_V;
    end else if (load) begin
      code_q <= code_in;
      wait_q <= wait_in;
    end
  end

  // R1: boot attributes right after reset
  a_r1_boot_attr: assert property (@(posedge clk)
    $fell(rst) |-> (wait_q == BOOT_WAIT_V && code_q == BOOT_CODE));
endmodule

// File: rtl/cst_wait_timer.sv
module cst_wait_timer #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              tick,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R12: every start reloads the counter
  a_r12_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
  // R2: one state per tick
  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/cst_ack_sampler.sv
module cst_ack_sampler #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] ack_n_in,
  output logic             seen
);
  logic [LINES-1:0] smp_n;

  // Size acknowledge lines are captured on the falling edge.
  always_ff @(negedge clk) begin
    if (rst) smp_n <= '1;
    else smp_n <= ack_n_in;
  end

  assign seen = ~&smp_n;
endmodule

// File: rtl/cs_cycle_term.sv
module cs_cycle_term
  import cst_pkg::*;
#(
  parameter int unsigned WAIT_W = 4,
  parameter int unsigned BOOT_WAIT = 14,
  parameter int unsigned SZ_LINES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_load,
  input  logic [1:0]          cfg_code,
  input  logic [WAIT_W-1:0]   cfg_wait,
  input  logic                alt_bus,
  input  logic                cyc_start,
  input  logic                cs_act,
  input  logic [SZ_LINES-1:0] ext_sz_ack_n,
  input  logic                ext_xfer_ack_n,
  output logic [SZ_LINES-1:0] sz_ack_n,
  output logic                sz_ack_oe,
  output logic                xfer_ack_n,
  output logic                xfer_ack_oe,
  output logic                done
);
  localparam logic [SZ_LINES-1:0] SZ_IDLE = '1;

  cst_state_t        state;
  logic [1:0]        attr_code, cyc_code;
  logic [WAIT_W-1:0] attr_wait;
  logic              cyc_alt;
  logic              cnt_load, cnt_tick, cnt_expired;
  logic              sz_seen, ext_hit, ext_mode;

  cst_attr_reg #(.WAIT_W(WAIT_W), .BOOT_WAIT(BOOT_WAIT), .BOOT_CODE(CODE_W32)) u_attr (
    .clk(clk), .rst(rst), .load(cfg_load), .code_in(cfg_code), .wait_in(cfg_wait),
    .code_q(attr_code), .wait_q(attr_wait));

  cst_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(attr_wait),
    .tick(cnt_tick), .expired(cnt_expired));

  cst_ack_sampler #(.LINES(SZ_LINES)) u_smp (
    .clk(clk), .rst(rst), .ack_n_in(ext_sz_ack_n), .seen(sz_seen));

  assign cnt_load = (state == ST_IDLE) && cyc_start && cs_act;
  assign cnt_tick = (state == ST_WAIT);
  assign ext_mode = (cyc_code == CODE_EXT);
  // Transfer acknowledge is taken at the rising edge itself, so a pulse
  // released before the cycle began can never count.
  assign ext_hit  = cyc_alt ? !ext_xfer_ack_n : sz_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cyc_code    <= CODE_W32;
      cyc_alt     <= 1'b0;
      sz_ack_n    <= SZ_IDLE;
      sz_ack_oe   <= 1'b0;
      xfer_ack_n  <= 1'b1;
      xfer_ack_oe <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cnt_load) begin
            state    <= ST_WAIT;
            cyc_code <= attr_code;
            cyc_alt  <= alt_bus;
          end
        end
        ST_WAIT: begin
          if (!cs_act) begin
            state <= ST_IDLE;
          end else if (ext_hit) begin
            state <= ST_ACK;
            done  <= 1'b1;
          end else if (!ext_mode && cnt_expired) begin
            state <= ST_ACK;
            done  <= 1'b1;
            if (cyc_alt) begin
              xfer_ack_n  <= 1'b0;
              xfer_ack_oe <= 1'b1;
            end else begin
              sz_ack_n  <= size_ack_pattern(cyc_code);
              sz_ack_oe <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (!cs_act) begin
            state       <= ST_IDLE;
            sz_ack_n    <= SZ_IDLE;
            sz_ack_oe   <= 1'b0;
            xfer_ack_n  <= 1'b1;
            xfer_ack_oe <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: external-response code never drives
  a_r4_ext_no_drive: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && cyc_code == CODE_EXT) |-> (!sz_ack_oe && !xfer_ack_oe));
  // R5: only one acknowledge bus is driven
  a_r5_single_bus: assert property (@(posedge clk) disable iff (rst)
    !(sz_ack_oe && xfer_ack_oe));
  // R3: a driven size pair is never the idle pattern
  a_r3_size_valid: assert property (@(posedge clk) disable iff (rst)
    sz_ack_oe |-> (sz_ack_n != SZ_IDLE));
  // R10: done lasts one clock
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: drivers released once chip-select is low
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!sz_ack_oe && !xfer_ack_oe));
  // R11: abort gives no done
  a_r11_abort: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !cs_act) |=> !done);
endmodule

// File: tb/cs_cycle_term_test.sv
module cs_cycle_term_test;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [1:0] cfg_code = 2'b00;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic alt_bus = 1'b0;
  logic cyc_start = 1'b0;
  logic cs_act = 1'b0;
  logic [1:0] ext_sz_ack_n = 2'b11;
  logic ext_xfer_ack_n = 1'b1;
  logic [1:0] sz_ack_n;
  logic sz_ack_oe, xfer_ack_n, xfer_ack_oe, done;

  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cs_cycle_term #(.WAIT_W(WAIT_W), .BOOT_WAIT(14), .SZ_LINES(2)) uut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_code(cfg_code), .cfg_wait(cfg_wait),
    .alt_bus(alt_bus), .cyc_start(cyc_start), .cs_act(cs_act),
    .ext_sz_ack_n(ext_sz_ack_n), .ext_xfer_ack_n(ext_xfer_ack_n),
    .sz_ack_n(sz_ack_n), .sz_ack_oe(sz_ack_oe), .xfer_ack_n(xfer_ack_n),
    .xfer_ack_oe(xfer_ack_oe), .done(done));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] code, input int w, input logic alt);
    @(negedge clk);
    cfg_load = 1'b1; cfg_code = code; cfg_wait = WAIT_W'(w); alt_bus = alt;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic begin_cycle();
    @(negedge clk);
    cs_act = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
  endtask

  // Negedges counted from the start edge until done is seen.
  task automatic measure(output int lat);
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic end_cycle(input string req);
    @(negedge clk);
    cs_act = 1'b0;
    @(negedge clk);
    chk({req, " sz_oe idle"}, int'(sz_ack_oe), 0);
    chk({req, " xfer_oe idle"}, int'(xfer_ack_oe), 0);
    chk({req, " sz pattern idle"}, int'(sz_ack_n), 3);
  endtask

  task automatic t_reset();
    int lat;
    chk("R1 sz_ack_n", int'(sz_ack_n), 3);
    chk("R1 enables", int'(sz_ack_oe | xfer_ack_oe), 0);
    chk("R1 xfer_ack_n", int'(xfer_ack_n), 1);
    chk("R1 done", int'(done), 0);
    begin_cycle();
    measure(lat);
    chk("R1 boot latency 14 waits", lat, 16);
    chk("R1 boot code 32-bit", int'(sz_ack_n), 0);
    end_cycle("R1");
  endtask

  task automatic t_sizes();
    int lat;
    for (int c = 0; c < 3; c++) begin
      configure(2'(c), 3, 1'b0);
      begin_cycle();
      measure(lat);
      chk("R2 latency wait 3", lat, 5);
      chk("R3 size pattern", int'(sz_ack_n), c);
      chk("R3 size enable", int'(sz_ack_oe), 1);
      @(negedge clk);
      chk("R10 done single pulse", int'(done), 0);
      @(negedge clk);
      chk("R10 ack held while cs", int'(sz_ack_oe), 1);
      end_cycle("R10");
    end
  endtask

  task automatic t_zero_wait();
    int lat;
    configure(2'b01, 0, 1'b0);
    begin_cycle();
    measure(lat);
    chk("R9 zero-wait latency", lat, 2);
    end_cycle("R9");
  endtask

  task automatic t_ext_size();
    configure(2'b11, 1, 1'b0);
    begin_cycle();
    repeat (5) @(negedge clk);
    chk("R4 no end without ack", int'(done), 0);
    @(posedge clk); #1 ext_sz_ack_n = 2'b01;
    @(negedge clk);
    @(negedge clk);
    chk("R4 ends on external ack", int'(done), 1);
    chk("R4 no drive", int'(sz_ack_oe | xfer_ack_oe), 0);
    ext_sz_ack_n = 2'b11;
    end_cycle("R4");
  endtask

  task automatic t_early();
    configure(2'b00, 12, 1'b0);
    begin_cycle();
    @(posedge clk); #1 ext_sz_ack_n = 2'b10;
    @(negedge clk);
    @(negedge clk);
    chk("R7 early end done", int'(done), 1);
    chk("R7 early end no drive", int'(sz_ack_oe | xfer_ack_oe), 0);
    ext_sz_ack_n = 2'b11;
    end_cycle("R7");
  endtask

  task automatic t_alt_int();
    int lat;
    configure(2'b01, 2, 1'b1);
    begin_cycle();
    measure(lat);
    chk("R5 alt latency", lat, 4);
    chk("R5 xfer_ack_n low", int'(xfer_ack_n), 0);
    chk("R5 xfer enable", int'(xfer_ack_oe), 1);
    chk("R5 size pair undriven", int'(sz_ack_oe), 0);
    end_cycle("R5");
  endtask

  task automatic t_alt_ext();
    configure(2'b11, 0, 1'b1);
    @(negedge clk); ext_xfer_ack_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_xfer_ack_n = 1'b1;
    begin_cycle();
    repeat (4) @(negedge clk);
    chk("R8 stale ack ignored", int'(done), 0);
    @(posedge clk); #1 ext_xfer_ack_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 ends on rising sample", int'(done), 1);
    chk("R6 no drive", int'(sz_ack_oe | xfer_ack_oe), 0);
    ext_xfer_ack_n = 1'b1;
    end_cycle("R6");
  endtask

  task automatic t_abort();
    int seen;
    configure(2'b00, 5, 1'b0);
    begin_cycle();
    @(negedge clk);
    cs_act = 1'b0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      seen |= int'(done | sz_ack_oe | xfer_ack_oe);
    end
    chk("R11 abort no done or drive", seen, 0);
  endtask

  task automatic t_reload();
    int lat;
    configure(2'b10, 6, 1'b0);
    begin_cycle();
    measure(lat);
    chk("R12 first count", lat, 8);
    end_cycle("R12");
    configure(2'b10, 1, 1'b0);
    begin_cycle();
    measure(lat);
    chk("R12 reloaded count", lat, 3);
    end_cycle("R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_zero_wait();
    t_ext_size();
    t_early();
    t_alt_int();
    t_alt_ext();
    t_abort();
    t_reload();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule